// File: doc/BRIEF.md
# Pin-Event Slow-Timer Timestamp Capture

This block records the value of a free-running 24-bit slow-timer count when a chosen pin's interrupt flag becomes set. A 2-bit port field and a 3-bit pin field pick one flag out of the flag vector. The flag is looked at only on rising edges of the slow (32 kHz) clock. That clock is brought into the fast clock domain by a synchroniser, which turns each of its rising edges into a one-cycle sample tick.

When the sampled flag goes from 0 to 1, the block stores the count plus one. It then raises a valid bit and presents the stored value as three byte outputs. Until software re-arms it, the block ignores further pin activity.

Re-arming is a fixed sequence. Software clears valid, the block waits for the slow clock to go low and then for its next rising edge, and software then clears the pin flag. Software may also change the selected pin. After a change of selection, the next flag sample is used only as a baseline, so a flag that was already set on the new pin does not produce a capture.

Top module: `st_pin_capture`

## Requirements
- R1: After reset, `valid` is 0 and the three capture bytes `cap_b0`, `cap_b1` and `cap_b2` are all 0x00.
- R2: The flag being watched is `pin_flags[sel_port*8 + sel_pin]`. A change on any other flag bit causes no capture.
- R3: A capture happens only at a rising edge of `slow_clk`, and only when the selected flag sampled at that edge is 1 while the previous sample was 0. A flag pulse that rises and falls between two slow edges causes no capture.
- R4: The stored value is (count at the capturing slow edge + 1) modulo 2^24. `cap_b0` holds bits 7:0, `cap_b1` holds bits 15:8 and `cap_b2` holds bits 23:16. A count of 0xFFFFFF therefore stores 0x000000.
- R5: `valid` goes to 1 with the capture. While `valid` is 1, the stored value holds and pin events are ignored, until a `clr_valid` pulse arrives.
- R6: A `clr_valid` pulse drops `valid` on the next cycle. The block accepts a new capture only after `slow_clk` has been seen low and then rising. A flag rise sampled at that arming edge itself causes no capture. A flag cleared and set again after arming is captured.
- R7: A flag that stays at 1 across the arming edge and later slow edges never causes a capture.
- R8: After `sel_port` or `sel_pin` changes, the next slow-edge sample only sets the baseline and never captures. This also applies when the change falls in the same cycle as the sample tick, in which case the change takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | 32 kHz clock level, synchronised inside |
| count | input | 24 | Running slow-timer count |
| pin_flags | input | 32 | Pin interrupt flags, index port*8+pin |
| sel_port | input | 2 | Port selection of the trigger pin |
| sel_pin | input | 3 | Pin selection inside the port |
| clr_valid | input | 1 | One-cycle pulse that clears valid and starts re-arming |
| cap_b0 | output | 8 | Stored value bits 7:0 |
| cap_b1 | output | 8 | Stored value bits 15:8 |
| cap_b2 | output | 8 | Stored value bits 23:16 |
| valid | output | 1 | Stored value is readable and the block is locked |

## Verification
A change of pin selection can fall in the same fast-clock cycle as the slow-edge sample tick, while the newly selected flag is already 1. The bench provokes this by raising `slow_clk` and then changing the selection exactly two fast edges later, which is the cycle in which the synchroniser's tick is high. The coincidence is judged correct if `valid` stays 0 at that edge and at the following edges. Once the flag is cleared and set again, a normal capture with count+1 must follow.

// File: rtl/st_cap_pkg.sv
package st_cap_pkg;
   typedef enum logic [1:0] {
      ARM_READY   = 2'd0,
      ARM_HELD    = 2'd1,
      ARM_WAIT_LO = 2'd2,
      ARM_WAIT_HI = 2'd3
   } arm_state_t;
endpackage

// File: rtl/st_slow_sync.sv
module st_slow_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_clk,
   output logic slow_lvl,
   output logic tick
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("st_slow_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         lvl_d  <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], slow_clk};
         lvl_d  <= sync_q[SYNC_STAGES-1];
      end
   end

   assign slow_lvl = sync_q[SYNC_STAGES-1];
   assign tick     = slow_lvl & ~lvl_d;

   // R3: a slow edge yields exactly one sample tick
   p_single_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/st_flag_select.sv
module st_flag_select #(
   parameter int PORT_W    = 2,
   parameter int PIN_W     = 3,
   parameter int NUM_PORTS = 4
) (
   input  logic [NUM_PORTS*(1<<PIN_W)-1:0] pin_flags,
   input  logic [PORT_W-1:0]               sel_port,
   input  logic [PIN_W-1:0]                sel_pin,
   output logic                            flag
);
   localparam int PINS  = 1 << PIN_W;
   localparam int TOTAL = NUM_PORTS * PINS;
   localparam int FULL  = 1 << (PORT_W + PIN_W);

   if (NUM_PORTS < 1 || NUM_PORTS > (1 << PORT_W)) begin : g_bad_ports
      $error("st_flag_select: NUM_PORTS out of range for PORT_W");
   end

   logic [FULL-1:0] padded;

   if (TOTAL == FULL) begin : g_full
      assign padded = pin_flags;
   end else begin : g_pad
      assign padded = {{(FULL-TOTAL){1'b0}}, pin_flags};
   end

   assign flag = padded[{sel_port, sel_pin}];
endmodule

// File: rtl/st_rearm_ctrl.sv
module st_rearm_ctrl
   import st_cap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic clr_valid,
   input  logic slow_lvl,
   input  logic tick,
   output logic armed,
   output logic valid
);
   arm_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARM_READY:   if (capture)   state_d = ARM_HELD;
         ARM_HELD:    if (clr_valid) state_d = ARM_WAIT_LO;
         ARM_WAIT_LO: if (!slow_lvl) state_d = ARM_WAIT_HI;
         ARM_WAIT_HI: if (tick)      state_d = ARM_READY;
         default:                    state_d = ARM_READY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ARM_READY;
      else        state_q <= state_d;
   end

   assign armed = (state_q == ARM_READY);
   assign valid = (state_q == ARM_HELD);

   // R6: arming only follows a slow rising edge
   p_arm_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(tick));
   // R5: valid is held until software clears it
   p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clr_valid) |=> valid);
endmodule

// File: rtl/st_pin_capture.sv
module st_pin_capture
   import st_cap_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int PORT_W      = 2,
   parameter int PIN_W       = 3,
   parameter int NUM_PORTS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            slow_clk,
   input  logic [CNT_W-1:0]                count,
   input  logic [NUM_PORTS*(1<<PIN_W)-1:0] pin_flags,
   input  logic [PORT_W-1:0]               sel_port,
   input  logic [PIN_W-1:0]                sel_pin,
   input  logic                            clr_valid,
   output logic [7:0]                      cap_b0,
   output logic [7:0]                      cap_b1,
   output logic [7:0]                      cap_b2,
   output logic                            valid
);
   localparam int SEL_W = PORT_W + PIN_W;

   if (CNT_W != 24) begin : g_bad_cnt
      $error("st_pin_capture: three byte outputs need CNT_W of 24");
   end

   logic slow_lvl, tick, flag, armed;

   st_slow_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
      .slow_lvl(slow_lvl), .tick(tick));

   st_flag_select #(.PORT_W(PORT_W), .PIN_W(PIN_W), .NUM_PORTS(NUM_PORTS)) u_sel (
      .pin_flags(pin_flags), .sel_port(sel_port), .sel_pin(sel_pin), .flag(flag));

   logic [SEL_W-1:0] sel_q;
   logic             sel_chg, hist_q, primed_q, rise, capture;
   logic [CNT_W-1:0] cap_q;

   assign sel_chg = ({sel_port, sel_pin} != sel_q);
   assign rise    = tick && !sel_chg && primed_q && flag && !hist_q;
   assign capture = rise && armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= '0;
         hist_q   <= 1'b0;
         primed_q <= 1'b0;
         cap_q    <= '0;
      end else begin
         sel_q <= {sel_port, sel_pin};
         if (sel_chg) begin
            primed_q <= 1'b0;
         end else if (tick) begin
            hist_q   <= flag;
            primed_q <= 1'b1;
         end
         if (capture) cap_q <= count + 1'b1;
      end
   end

   st_rearm_ctrl u_arm (
      .clk(clk), .rst_n(rst_n), .capture(capture), .clr_valid(clr_valid),
      .slow_lvl(slow_lvl), .tick(tick), .armed(armed), .valid(valid));

   assign cap_b0 = cap_q[7:0];
   assign cap_b1 = cap_q[15:8];
   assign cap_b2 = cap_q[23:16];

   // R3: a capture appears only right after a sample tick
   p_cap_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(tick));
   // R4: stored value is the sampled count plus one
   p_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> (cap_q == CNT_W'($past(count) + 1'b1)));
   // R5: stored value is frozen while valid
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> $stable(cap_q));
   // R8: a selection change never yields a capture in the next cycle
   p_selchg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_chg && !valid) |=> !valid);
endmodule

// File: tb/st_pin_capture_tb.sv
`timescale 1ns/1ps
module st_pin_capture_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_clk = 1'b0;
   logic [23:0] count = '0;
   logic [31:0] pin_flags = '0;
   logic [1:0]  sel_port = '0;
   logic [2:0]  sel_pin = '0;
   logic        clr_valid = 1'b0;
   logic [7:0]  cap_b0, cap_b1, cap_b2;
   logic        valid;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   st_pin_capture u_dut (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .count(count),
      .pin_flags(pin_flags), .sel_port(sel_port), .sel_pin(sel_pin),
      .clr_valid(clr_valid), .cap_b0(cap_b0), .cap_b1(cap_b1),
      .cap_b2(cap_b2), .valid(valid));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_cap(input string req, input logic v, input logic [23:0] val);
      check(req, {31'd0, valid}, {31'd0, v});
      if (v) check(req, {8'd0, cap_b2, cap_b1, cap_b0}, {8'd0, val});
   endtask

   task automatic slow_cycle();
      @(negedge clk) slow_clk = 1'b0;
      repeat (6) @(negedge clk);
      slow_clk = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk) clr_valid = 1'b1;
      @(negedge clk) clr_valid = 1'b0;
   endtask

   task automatic rearm(input int idx);
      pulse_clr();
      pin_flags[idx] = 1'b0;
      slow_cycle();
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check_cap("R1 valid", 1'b0, 24'h0);
      check("R1 bytes", {8'd0, cap_b2, cap_b1, cap_b0}, 32'h0);
      slow_cycle();
   endtask

   task automatic t_basic();
      count = 24'h123455;
      pin_flags[0] = 1'b1;
      slow_cycle();
      check_cap("R3/R4 capture", 1'b1, 24'h123456);
      check("R4 byte order", {8'd0, cap_b2, cap_b1, cap_b0}, 32'h00123456);
   endtask

   task automatic t_hold();
      count = 24'h000500;
      pin_flags[0] = 1'b0;
      slow_cycle();
      pin_flags[0] = 1'b1;
      slow_cycle();
      check_cap("R5 held while valid", 1'b1, 24'h123456);
   endtask

   task automatic t_rearm();
      pin_flags[0] = 1'b0;
      slow_cycle();
      pulse_clr();
      check("R6 clr drops valid", {31'd0, valid}, 32'd0);
      pin_flags[0] = 1'b1;
      slow_cycle();
      check_cap("R6 rise at arming edge ignored", 1'b0, 24'h0);
      slow_cycle();
      check_cap("R7 steady flag no retrigger", 1'b0, 24'h0);
      pin_flags[0] = 1'b0;
      slow_cycle();
      count = 24'h00ABCD;
      pin_flags[0] = 1'b1;
      slow_cycle();
      check_cap("R6 capture after re-arm", 1'b1, 24'h00ABCE);
   endtask

   task automatic t_glitch();
      rearm(0);
      @(negedge clk) slow_clk = 1'b0;
      repeat (2) @(negedge clk);
      pin_flags[0] = 1'b1;
      repeat (2) @(negedge clk);
      pin_flags[0] = 1'b0;
      repeat (2) @(negedge clk);
      slow_clk = 1'b1;
      repeat (6) @(negedge clk);
      check_cap("R3 pulse between edges ignored", 1'b0, 24'h0);
   endtask

   task automatic t_select();
      sel_port = 2'd2;
      sel_pin  = 3'd5;
      slow_cycle();
      pin_flags[0] = 1'b1;
      slow_cycle();
      check_cap("R2 other flag ignored", 1'b0, 24'h0);
      count = 24'h7F00FF;
      pin_flags[21] = 1'b1;
      slow_cycle();
      check_cap("R2 selected flag 21 captured", 1'b1, 24'h7F0100);
   endtask

   task automatic t_wrap();
      rearm(21);
      count = 24'hFFFFFF;
      pin_flags[21] = 1'b1;
      slow_cycle();
      check_cap("R4 wrap to zero", 1'b1, 24'h000000);
   endtask

   task automatic t_selchg_tick();
      rearm(21);
      pin_flags[25] = 1'b1;
      @(negedge clk) slow_clk = 1'b0;
      repeat (6) @(negedge clk);
      slow_clk = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      sel_port = 2'd3;
      sel_pin  = 3'd1;
      repeat (8) @(negedge clk);
      check_cap("R8 change in tick cycle", 1'b0, 24'h0);
      slow_cycle();
      check_cap("R8 set flag is baseline", 1'b0, 24'h0);
      pin_flags[25] = 1'b0;
      slow_cycle();
      count = 24'h000010;
      pin_flags[25] = 1'b1;
      slow_cycle();
      check_cap("R8 capture after baseline", 1'b1, 24'h000011);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_hold();
      t_rearm();
      t_glitch();
      t_select();
      t_wrap();
      t_selchg_tick();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule